// File: doc/BRIEF.md
# Asynchronous SRAM Bus Bridge

This block connects a simple on-chip request port to an external asynchronous SRAM whose data path is 16 bits wide. A request carries a byte address, a direction and a size of 8, 16 or 32 bits. The bridge turns it into one or two external accesses and returns a single response, carrying read data or an alignment error.

Every external access has three phases in a fixed order. An address setup phase comes first, then a data phase with the strobes active, then an optional address hold phase and an optional bus turnaround gap. The length of each phase comes from a configuration input. Chip enable, output enable, write enable and the two byte-lane enables are all active low. The bidirectional data bus is modelled as separate in, out and drive-enable signals. The address on the pins is a 21-bit halfword address.

Top module: `sram_bridge`

## Requirements
- R1: `reqReady` is high only while the bridge is idle. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. Each accepted request gives exactly one single-cycle `rspValid` pulse, and `reqReady` returns high in the cycle after that pulse.
- R2: A 16-bit request (`reqSize`=1) with `reqAddr[0]`=0 performs exactly one external access at halfword address `reqAddr[21:1]`.
- R3: A 32-bit request (`reqSize`=2 or 3) with `reqAddr[0]`=0 performs two accesses. The first goes to halfword `reqAddr[21:1]` and carries `reqWData[15:0]`. The second goes to the next halfword and carries `reqWData[31:16]`. Read data returns as {second, first}. The address holds steady within one access.
- R4: For an 8-bit write (`reqSize`=0), only one lane is enabled. An even address gives `sramBlN`=2'b10 and an odd address gives 2'b01. Both lanes carry the write byte. Lane 0 is bits [7:0] and lane 1 is bits [15:8].
- R5: During a read access both byte-lane enables are low and `sramOeN` is low for the whole data phase. An 8-bit read returns, zero-extended, bits [7:0] of the word for an even address and bits [15:8] for an odd address.
- R6: `sramWeN` is low only during the data phase of a write. It is never low together with `sramOeN`.
- R7: For writes, `sramDqOe` is high through the setup and data phases and low during hold, turnaround and idle. It is never high for a read.
- R8: Setup and data phases last `cfgSetup` and `cfgData` cycles, with 0 treated as 1. Hold and turnaround last `cfgHold` and `cfgTurn` cycles, and 0 skips the phase. Chip enable is low during setup, data and hold, and high during turnaround.
- R9: A 16-bit or 32-bit request with `reqAddr[0]`=1 performs no external access. It responds in the cycle after acceptance with `rspErr`=1 and `rspRData`=0.
- R10: Read data is sampled from `sramDqIn` at the end of the last data-phase cycle only. `rspRData` is valid while `rspValid` is high.
- R11: After reset all strobes are high, `sramBlN`=2'b11, `sramDqOe`=0, `reqReady`=1 and `rspValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSetup | input | 4 | Address setup cycles |
| cfgHold | input | 4 | Address hold cycles |
| cfgData | input | 4 | Data phase cycles |
| cfgTurn | input | 4 | Bus turnaround cycles |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Bridge idle, request accepted |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| reqAddr | input | 22 | Byte address |
| reqWData | input | 32 | Write data |
| rspValid | output | 1 | Response pulse |
| rspErr | output | 1 | Alignment error |
| rspRData | output | 32 | Read data |
| sramCeN | output | 1 | Chip enable, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramBlN | output | 2 | Byte-lane enables, active low |
| sramAddr | output | 21 | Halfword address |
| sramDqOut | output | 16 | Data driven to memory |
| sramDqOe | output | 1 | Data bus drive enable |
| sramDqIn | input | 16 | Data from memory |

## Verification
The embedded properties check several rules on every cycle. Write and output enables are never active together, and write enable only occurs with chip enable. Reads always enable both lanes, and the bridge never drives the bus while output enable is low. The address holds within an access, handshakes are single-pulse, and a misaligned request responds at once. The exact phase lengths for each configuration, the lane choice for odd and even bytes, the halfword order of split requests and the byte selected on reads can only be shown by the bench's scenarios. There, a cycle-exact expected trace is compared pin by pin against the design. Memory data is made valid only in the final data cycle, so that the sampling point is pinned down.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;      // capture a newly accepted request
    logic advance;   // step to the upper halfword of a split request
    logic capture;   // last data-phase cycle: sample read data
    logic inAccess;  // setup, data or hold phase: chip selected
    logic inData;    // data phase
    logic drive;     // setup or data phase: write data may be driven
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_DATA, ST_HOLD, ST_TURN, ST_DONE
  } state_t;

endpackage

// File: rtl/sram_bridge_ctrl.sv
module sram_bridge_ctrl
  import sram_bridge_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] cfgData,
  input  logic [CNT_W-1:0] cfgTurn,
  input  logic             reqValid,
  input  logic [1:0]       reqSize,
  input  logic             reqAddrLsb,
  output logic             reqReady,
  output logic             rspValid,
  output logic             rspErr,
  output strobe_t          strb
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             isSplit;
  logic             upperBeat;
  logic             errFlag;

  logic [CNT_W-1:0] setupLen, dataLen;
  logic             phaseEnd, endBeat, advance, badAlign;

  assign setupLen = (cfgSetup == ZERO) ? ONE : cfgSetup;
  assign dataLen  = (cfgData  == ZERO) ? ONE : cfgData;
  assign phaseEnd = (cnt == ZERO);
  assign badAlign = (reqSize != 2'd0) && reqAddrLsb;

  always_comb begin
    endBeat = 1'b0;
    if (phaseEnd) begin
      unique case (state)
        ST_DATA: endBeat = (cfgHold == ZERO) && (cfgTurn == ZERO);
        ST_HOLD: endBeat = (cfgTurn == ZERO);
        ST_TURN: endBeat = 1'b1;
        default: endBeat = 1'b0;
      endcase
    end
  end

  assign advance = endBeat && isSplit && !upperBeat;

  assign reqReady      = (state == ST_IDLE);
  assign rspValid      = (state == ST_DONE);
  assign rspErr        = errFlag;
  assign strb.load     = reqReady && reqValid;
  assign strb.advance  = advance;
  assign strb.capture  = (state == ST_DATA) && phaseEnd;
  assign strb.inAccess = (state == ST_SETUP) || (state == ST_DATA) || (state == ST_HOLD);
  assign strb.inData   = (state == ST_DATA);
  assign strb.drive    = (state == ST_SETUP) || (state == ST_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= ZERO;
      isSplit   <= 1'b0;
      upperBeat <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            isSplit   <= reqSize[1];
            upperBeat <= 1'b0;
            errFlag   <= badAlign;
            if (badAlign) begin
              state <= ST_DONE;
            end else begin
              state <= ST_SETUP;
              cnt   <= setupLen - ONE;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: begin
          if (!phaseEnd) begin
            cnt <= cnt - ONE;
          end else if (endBeat) begin
            if (advance) begin
              upperBeat <= 1'b1;
              state     <= ST_SETUP;
              cnt       <= setupLen - ONE;
            end else begin
              state <= ST_DONE;
            end
          end else begin
            unique case (state)
              ST_SETUP: begin state <= ST_DATA; cnt <= dataLen - ONE; end
              ST_DATA: begin
                if (cfgHold != ZERO) begin state <= ST_HOLD; cnt <= cfgHold - ONE; end
                else begin state <= ST_TURN; cnt <= cfgTurn - ONE; end
              end
              default: begin state <= ST_TURN; cnt <= cfgTurn - ONE; end
            endcase
          end
        end
      endcase
    end
  end

  // handshake: acceptance drops ready for the following cycle (R1)
  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // response is a single pulse followed by idle (R1)
  assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  // misaligned request answers at once with an error (R9)
  assert_err_fast_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && badAlign) |=> (rspValid && rspErr));

endmodule

// File: rtl/sram_bridge_dp.sv
module sram_bridge_dp
  import sram_bridge_pkg::*;
#(
  parameter int HADDR_W = 21,
  parameter int DQ_W    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic                 reqWrite,
  input  logic [1:0]           reqSize,
  input  logic [HADDR_W:0]     reqAddr,
  input  logic [2*DQ_W-1:0]    reqWData,
  output logic [2*DQ_W-1:0]    rspRData,
  output logic                 sramCeN,
  output logic                 sramOeN,
  output logic                 sramWeN,
  output logic [1:0]           sramBlN,
  output logic [HADDR_W-1:0]   sramAddr,
  output logic [DQ_W-1:0]      sramDqOut,
  output logic                 sramDqOe,
  input  logic [DQ_W-1:0]      sramDqIn
);

  localparam int BYTE_W = DQ_W / 2;
  localparam int LANES  = 2;
  localparam logic [HADDR_W-1:0] HSTEP = {{(HADDR_W-1){1'b0}}, 1'b1};

  logic                isWrite, szByte, szWord, oddByte, hiBeat;
  logic [HADDR_W-1:0]  haddr;
  logic [2*DQ_W-1:0]   wdata;
  logic [DQ_W-1:0]     rdLo, rdHi;
  logic [LANES-1:0]    laneOn;
  logic [BYTE_W-1:0]   pickedByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isWrite <= 1'b0;
      szByte  <= 1'b0;
      szWord  <= 1'b0;
      oddByte <= 1'b0;
      hiBeat  <= 1'b0;
      haddr   <= '0;
      wdata   <= '0;
      rdLo    <= '0;
      rdHi    <= '0;
    end else begin
      if (strb.load) begin
        isWrite <= reqWrite;
        szByte  <= (reqSize == 2'd0);
        szWord  <= reqSize[1];
        oddByte <= reqAddr[0];
        hiBeat  <= 1'b0;
        haddr   <= reqAddr[HADDR_W:1];
        wdata   <= reqWData;
        rdLo    <= '0;
        rdHi    <= '0;
      end else if (strb.advance) begin
        hiBeat <= 1'b1;
        haddr  <= haddr + HSTEP;
      end
      if (strb.capture && !isWrite) begin
        if (hiBeat) rdHi <= sramDqIn;
        else        rdLo <= sramDqIn;
      end
    end
  end

  // lane g is enabled for a byte access only when the address parity selects it
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneOn[g] = !szByte || (oddByte == (g == 1));
  end

  assign pickedByte = oddByte ? rdLo[DQ_W-1:BYTE_W] : rdLo[BYTE_W-1:0];

  always_comb begin
    if (szWord)      rspRData = {rdHi, rdLo};
    else if (szByte) rspRData = {{(DQ_W+BYTE_W){1'b0}}, pickedByte};
    else             rspRData = {{DQ_W{1'b0}}, rdLo};
  end

  assign sramCeN   = !strb.inAccess;
  assign sramOeN   = !(strb.inData && !isWrite);
  assign sramWeN   = !(strb.inData && isWrite);
  assign sramBlN   = !strb.inAccess ? 2'b11 : (isWrite ? ~laneOn : 2'b00);
  assign sramAddr  = haddr;
  assign sramDqOe  = strb.drive && isWrite;
  assign sramDqOut = hiBeat ? wdata[2*DQ_W-1:DQ_W]
                   : (szByte ? {2{wdata[BYTE_W-1:0]}} : wdata[DQ_W-1:0]);

  logic advanceBit;
  assign advanceBit = strb.advance;

  // write and read strobes never overlap (R6)
  assert_we_oe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramWeN && !sramOeN));

  // write strobe only inside a selected access (R6)
  assert_we_in_access_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> !sramCeN);

  // reads use both lanes (R5)
  assert_read_lanes_R5: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> (sramBlN == 2'b00));

  // no bus contention while memory drives (R7)
  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> !sramDqOe);

  // address steady within one access (R3)
  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN) && !$past(advanceBit)) |-> $stable(sramAddr));

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int HADDR_W = 21,
  parameter int DQ_W    = 16,
  parameter int CNT_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    cfgSetup,
  input  logic [CNT_W-1:0]    cfgHold,
  input  logic [CNT_W-1:0]    cfgData,
  input  logic [CNT_W-1:0]    cfgTurn,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [1:0]          reqSize,
  input  logic [HADDR_W:0]    reqAddr,
  input  logic [2*DQ_W-1:0]   reqWData,
  output logic                rspValid,
  output logic                rspErr,
  output logic [2*DQ_W-1:0]   rspRData,
  output logic                sramCeN,
  output logic                sramOeN,
  output logic                sramWeN,
  output logic [1:0]          sramBlN,
  output logic [HADDR_W-1:0]  sramAddr,
  output logic [DQ_W-1:0]     sramDqOut,
  output logic                sramDqOe,
  input  logic [DQ_W-1:0]     sramDqIn
);

  strobe_t strb;

  sram_bridge_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgSetup(cfgSetup), .cfgHold(cfgHold), .cfgData(cfgData), .cfgTurn(cfgTurn),
    .reqValid(reqValid), .reqSize(reqSize), .reqAddrLsb(reqAddr[0]),
    .reqReady(reqReady), .rspValid(rspValid), .rspErr(rspErr), .strb(strb)
  );

  sram_bridge_dp #(.HADDR_W(HADDR_W), .DQ_W(DQ_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr), .reqWData(reqWData),
    .rspRData(rspRData),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN), .sramBlN(sramBlN),
    .sramAddr(sramAddr), .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

endmodule

// File: tb/sim_sram_bridge.sv
module sim_sram_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cfgSetup = 4'd3, cfgHold = 4'd1, cfgData = 4'd6, cfgTurn = 4'd1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [21:0] reqAddr = '0;
  logic [31:0] reqWData = '0;
  logic [15:0] sramDqIn = 16'hDEAD;
  logic        reqReady, rspValid, rspErr, sramCeN, sramOeN, sramWeN, sramDqOe;
  logic [31:0] rspRData;
  logic [1:0]  sramBlN;
  logic [20:0] sramAddr;
  logic [15:0] sramDqOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  sram_bridge u0 (
    .clk(clk), .rstN(rstN),
    .cfgSetup(cfgSetup), .cfgHold(cfgHold), .cfgData(cfgData), .cfgTurn(cfgTurn),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWData(reqWData),
    .rspValid(rspValid), .rspErr(rspErr), .rspRData(rspRData),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN), .sramBlN(sramBlN),
    .sramAddr(sramAddr), .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  typedef struct {
    logic        ce, oe, we;
    logic [1:0]  bl;
    logic        chkAddr;
    logic [20:0] addr;
    logic        dqOe;
    logic [15:0] dq;
    logic        lastD;
    logic        rsp, err;
    logic [31:0] rd;
    logic        ready;
  } exp_t;

  exp_t q[$];

  function automatic logic [15:0] pat(input logic [20:0] h);
    return {h[7:0] ^ 8'hC3, h[15:8] ^ h[7:0] ^ 8'h5A};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic exp_t idleE(input logic rdy);
    exp_t e = '{ce:1'b1, oe:1'b1, we:1'b1, bl:2'b11, chkAddr:1'b0, addr:'0,
                dqOe:1'b0, dq:'0, lastD:1'b0, rsp:1'b0, err:1'b0, rd:'0, ready:rdy};
    return e;
  endfunction

  task automatic pushAccess(input logic wr, input logic [1:0] bl,
                            input logic [20:0] h, input logic [15:0] wd);
    int s = (cfgSetup == 0) ? 1 : int'(cfgSetup);
    int d = (cfgData == 0) ? 1 : int'(cfgData);
    exp_t e;
    e = idleE(1'b0);
    e.ce = 1'b0; e.bl = bl; e.chkAddr = 1'b1; e.addr = h;
    for (int i = 0; i < s; i++) begin
      e.dqOe = wr; e.dq = wd; q.push_back(e);
    end
    for (int i = 0; i < d; i++) begin
      e.oe = wr; e.we = !wr; e.dqOe = wr; e.dq = wd;
      e.lastD = (i == d - 1) && !wr;
      q.push_back(e);
    end
    e.oe = 1'b1; e.we = 1'b1; e.dqOe = 1'b0; e.lastD = 1'b0;
    for (int i = 0; i < int'(cfgHold); i++) q.push_back(e);
    for (int i = 0; i < int'(cfgTurn); i++) q.push_back(idleE(1'b0));
  endtask

  task automatic doReq(input logic wr, input logic [1:0] sz,
                       input logic [21:0] a, input logic [31:0] wd);
    logic        bad = (sz != 2'd0) && a[0];
    logic [20:0] h = a[21:1];
    logic [1:0]  bl;
    logic [31:0] rd;
    exp_t e, cur;
    if (!bad) begin
      bl = (wr && sz == 2'd0) ? (a[0] ? 2'b01 : 2'b10) : 2'b00;
      pushAccess(wr, bl, h, (sz == 2'd0) ? {2{wd[7:0]}} : wd[15:0]);
      if (sz[1]) pushAccess(wr, bl, h + 21'd1, wd[31:16]);
    end
    if (bad || wr)         rd = '0;
    else if (sz == 2'd0)   rd = {24'd0, a[0] ? pat(h)[15:8] : pat(h)[7:0]};
    else if (sz == 2'd1)   rd = {16'd0, pat(h)};
    else                   rd = {pat(h + 21'd1), pat(h)};
    e = idleE(1'b0); e.rsp = 1'b1; e.err = bad; e.rd = rd;
    q.push_back(e);
    q.push_back(idleE(1'b1));

    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = a; reqWData = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (q.size() > 0) begin
      cur = q.pop_front();
      sramDqIn = cur.lastD ? pat(cur.addr) : 16'hDEAD;
      check("R8", "ceN", {31'd0, sramCeN}, {31'd0, cur.ce});
      check("R5", "oeN", {31'd0, sramOeN}, {31'd0, cur.oe});
      check("R6", "weN", {31'd0, sramWeN}, {31'd0, cur.we});
      check("R4", "blN", {30'd0, sramBlN}, {30'd0, cur.bl});
      if (cur.chkAddr) check("R3", "addr", {11'd0, sramAddr}, {11'd0, cur.addr});
      check("R7", "dqOe", {31'd0, sramDqOe}, {31'd0, cur.dqOe});
      if (cur.dqOe) check("R7", "dqOut", {16'd0, sramDqOut}, {16'd0, cur.dq});
      check("R1", "rspValid", {31'd0, rspValid}, {31'd0, cur.rsp});
      check("R1", "reqReady", {31'd0, reqReady}, {31'd0, cur.ready});
      if (cur.rsp) begin
        check("R9", "rspErr", {31'd0, rspErr}, {31'd0, cur.err});
        check("R10", "rspRData", rspRData, cur.rd);
      end
      if (q.size() > 0) @(negedge clk);
    end
    sramDqIn = 16'hDEAD;
  endtask

  task automatic setCfg(input int s, input int hd, input int d, input int t);
    @(negedge clk);
    cfgSetup = 4'(s); cfgHold = 4'(hd); cfgData = 4'(d); cfgTurn = 4'(t);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11", "ceN", {31'd0, sramCeN}, 32'd1);
    check("R11", "oeN", {31'd0, sramOeN}, 32'd1);
    check("R11", "weN", {31'd0, sramWeN}, 32'd1);
    check("R11", "blN", {30'd0, sramBlN}, 32'd3);
    check("R11", "dqOe", {31'd0, sramDqOe}, 32'd0);
    check("R11", "reqReady", {31'd0, reqReady}, 32'd1);
    check("R11", "rspValid", {31'd0, rspValid}, 32'd0);

    // R2 R6 R7: aligned halfword write and read, default timing 3/6/1 + hold 1
    doReq(1'b1, 2'd1, 22'h000124, 32'h0000BEEF);
    // R5 R10: halfword read
    doReq(1'b0, 2'd1, 22'h000124, 32'h0);
    // R4: byte writes, even then odd lane
    doReq(1'b1, 2'd0, 22'h001000, 32'h000000A7);
    doReq(1'b1, 2'd0, 22'h001001, 32'h0000003C);
    // R5: byte reads, odd and even
    doReq(1'b0, 2'd0, 22'h0021A7, 32'h0);
    doReq(1'b0, 2'd0, 22'h0021A6, 32'h0);
    // R3: split word write and read, including halfword carry
    doReq(1'b1, 2'd2, 22'h00FFFE, 32'h12345678);
    doReq(1'b0, 2'd3, 22'h0A0010, 32'h0);
    // R9: misaligned halfword and word
    doReq(1'b0, 2'd1, 22'h000333, 32'h0);
    doReq(1'b1, 2'd2, 22'h000101, 32'hFFFFFFFF);
    // R8: zero counts (setup/data forced to 1, hold/turn skipped)
    setCfg(0, 0, 0, 0);
    doReq(1'b0, 2'd2, 22'h3FFFFC, 32'h0);
    doReq(1'b1, 2'd2, 22'h000040, 32'hCAFEF00D);
    // R8: other counts
    setCfg(1, 2, 2, 3);
    doReq(1'b1, 2'd0, 22'h000203, 32'h00000055);
    doReq(1'b0, 2'd2, 22'h000204, 32'h0);
    setCfg(2, 0, 1, 2);
    doReq(1'b0, 2'd1, 22'h00ABC2, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule